// File: doc/BRIEF.md
# Multi-Core Inter-Processor Interrupt Register Bank

This block keeps a separate set of inter-processor interrupt registers for each of a parameterised number of cores. Each set contains a pending-status word, an enable word, two write-only ports that set or clear status bits, and eight 32-bit mailbox words. Each set drives its own interrupt line. A 32-bit register bus with a requester ID reaches the bank. The requester ID selects which core's set an access touches, and only the low 8 bits of the address are decoded.

A separate send-command input lets any agent raise one status bit in any core's set. The command carries a 10-bit target core number in bits 25:16 and a 5-bit vector in bits 4:0. The interrupt line follows a deliberately asymmetric rule. It goes high when a set or send leaves some enabled bit pending. It goes low only when a clear write empties the whole status word while the enable word is nonzero. Writing the enable word never moves the line.

Bus responses are produced by a small response state machine. In `RS_IDLE` no response is shown. `RS_DATA` gives an OK response with read data, and `RS_DERR` gives a decode error. On every clock edge the machine goes to `RS_DATA` if a request arrives with a valid requester ID. It goes to `RS_DERR` if the requester ID is out of range, and to `RS_IDLE` if no request arrives. Every request is therefore answered exactly one cycle later.

Top module: `ipi_bank`

## Requirements
- R1: After reset, every status, enable and mailbox word reads zero, every interrupt output is low, and no response is shown.
- R2: A request whose requester ID is not below NUM_CORES is answered next cycle with rsp_err high and rsp_rdata zero, and it changes no register.
- R3: Within a core window, offset 0x00 reads status and offset 0x04 reads enable. The set port (0x08) and the clear port (0x0C) always read zero. Any unmapped offset reads zero, ignores writes and answers OK.
- R4: A write to offset 0x08 ORs the data into status. The interrupt output goes high after that write if status AND enable is nonzero.
- R5: A write to offset 0x0C clears the written bits of status. The interrupt output goes low only if status becomes zero while enable is nonzero; otherwise it keeps its level.
- R6: A write to the enable word at 0x04 never changes the interrupt output.
- R7: A write to the status offset 0x00 leaves status unchanged and pulses ro_wr_err for one cycle, in the cycle after the write.
- R8: Offsets 0x20 to 0x3F hold the eight mailbox words, with word index (offset - 0x20) >> 2. Each core has its own mailbox words.
- R9: A send command sets bit snd_cmd[4:0] in the status of core snd_cmd[25:16] and raises that core's interrupt under the same rule as R4. All other command bits are ignored. One cycle later snd_done pulses with snd_err low.
- R10: A send command whose target is not below NUM_CORES pulses snd_done with snd_err high and changes no status or interrupt.
- R11: Only req_addr[7:0] is decoded, so address bits above bit 7 have no effect.
- R12: rsp_valid is high exactly in the cycle after each accepted request.
- R13: If a clear write and a send command reach the same core in the same cycle, both take effect. The sent bit survives, and the interrupt rules are applied to the resulting status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; only bits 7:0 decoded |
| req_wdata | input | 32 | Write data |
| req_id | input | ID_W | Requester ID selecting the core set |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Decode error response |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| ro_wr_err | output | 1 | Pulse: a write hit the read-only status word |
| snd_valid | input | 1 | Send command present this cycle |
| snd_cmd | input | 32 | Send command: target in 25:16, vector in 4:0 |
| snd_done | output | 1 | Pulse: send command handled |
| snd_err | output | 1 | Send target out of range |
| irq | output | NUM_CORES | One interrupt line per core |

## Verification
The set/clear path is tested with overlapping bit patterns, so that a clear leaving some bits pending can be told apart from a clear that empties status. Both are run with enable zero and with enable nonzero, which separates the asymmetric lowering rule from a simple status-AND-enable level. Mailbox words are written with distinct values on two cores to expose an index or core-select fault. Send commands carry junk in the ignored fields and targets both in and out of range. A clear and a send are also driven in the same cycle to show how the two merge.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int DATA_W     = 32;
    localparam int MBOX_WORDS = 8;
    localparam int MIDX_W     = $clog2(MBOX_WORDS);
    localparam int VEC_W      = $clog2(DATA_W);

    // word offsets (byte offset >> 2) inside a core window
    localparam logic [5:0] W_STATUS = 6'd0;
    localparam logic [5:0] W_ENABLE = 6'd1;
    localparam logic [5:0] W_SET    = 6'd2;
    localparam logic [5:0] W_CLEAR  = 6'd3;

    typedef enum logic [2:0] {
        K_NONE, K_STATUS, K_ENABLE, K_SET, K_CLEAR, K_MBOX
    } kind_e;

    typedef enum logic [1:0] {
        RS_IDLE, RS_DATA, RS_DERR
    } rsp_state_e;
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
    import ipi_pkg::*;
(
    input  logic [5:0]        word,
    output kind_e             kind,
    output logic [MIDX_W-1:0] mbx_idx
);
    always_comb begin
        mbx_idx = word[MIDX_W-1:0];
        kind    = K_NONE;
        if (word[5:3] == 3'b001) begin
            kind = K_MBOX;
        end else begin
            unique case (word)
                W_STATUS: kind = K_STATUS;
                W_ENABLE: kind = K_ENABLE;
                W_SET:    kind = K_SET;
                W_CLEAR:  kind = K_CLEAR;
                default:  kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ipi_core_regs.sv
module ipi_core_regs
    import ipi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  kind_e             kind,
    input  logic [MIDX_W-1:0] mbx_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              snd_hit,
    input  logic [VEC_W-1:0]  snd_vec,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] status, enable;
    logic [MBOX_WORDS-1:0][DATA_W-1:0] mbx;
    logic [DATA_W-1:0] set_bits, clr_bits, status_nx;
    logic set_evt, clr_evt, raise, lower;

    always_comb begin
        set_evt   = (bus_we && kind == K_SET) || snd_hit;
        clr_evt   = bus_we && kind == K_CLEAR;
        set_bits  = (bus_we && kind == K_SET) ? wdata : '0;
        if (snd_hit) set_bits = set_bits | (DATA_W'(1) << snd_vec);
        clr_bits  = clr_evt ? wdata : '0;
        status_nx = (status & ~clr_bits) | set_bits;
        raise     = set_evt && ((status_nx & enable) != '0);
        lower     = clr_evt && (status_nx == '0) && (enable != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
            irq    <= 1'b0;
            for (int w = 0; w < MBOX_WORDS; w++) mbx[w] <= '0;
        end else begin
            status <= status_nx;
            if (bus_we && kind == K_ENABLE) enable <= wdata;
            if (bus_we && kind == K_MBOX)   mbx[mbx_idx] <= wdata;
            if (raise)      irq <= 1'b1;
            else if (lower) irq <= 1'b0;
        end
    end

    always_comb begin
        unique case (kind)
            K_STATUS: rdata = status;
            K_ENABLE: rdata = enable;
            K_MBOX:   rdata = mbx[mbx_idx];
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/ipi_bank.sv
module ipi_bank
    import ipi_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 16,
    parameter int ID_W      = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [ID_W-1:0]      req_id,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 ro_wr_err,
    input  logic                 snd_valid,
    input  logic [DATA_W-1:0]    snd_cmd,
    output logic                 snd_done,
    output logic                 snd_err,
    output logic [NUM_CORES-1:0] irq
);
    localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    localparam int TGT_W = 10;
    localparam int TGT_LO = 16;

    kind_e             kind;
    logic [MIDX_W-1:0] mbx_idx;
    logic              id_ok, tgt_ok;
    logic [TGT_W-1:0]  tgt;
    logic [NUM_CORES-1:0][DATA_W-1:0] core_rdata;
    logic [DATA_W-1:0] sel_rdata;
    rsp_state_e        state, state_nx;
    logic [DATA_W-1:0] rdata_q;

    logic unused_bits;
    assign unused_bits = ^{req_addr[ADDR_W-1:8], req_addr[1:0],
                           snd_cmd[DATA_W-1:TGT_LO+TGT_W], snd_cmd[TGT_LO-1:VEC_W]};

    ipi_addr_decode u_dec (
        .word    (req_addr[7:2]),
        .kind    (kind),
        .mbx_idx (mbx_idx)
    );

    assign id_ok  = req_id < ID_W'(NUM_CORES);
    assign tgt    = snd_cmd[TGT_LO +: TGT_W];
    assign tgt_ok = tgt < TGT_W'(NUM_CORES);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        ipi_core_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .bus_we  (req_valid && req_write && id_ok && req_id == ID_W'(c)),
            .kind    (kind),
            .mbx_idx (mbx_idx),
            .wdata   (req_wdata),
            .snd_hit (snd_valid && tgt_ok && tgt == TGT_W'(c)),
            .snd_vec (snd_cmd[VEC_W-1:0]),
            .rdata   (core_rdata[c]),
            .irq     (irq[c])
        );
    end

    assign sel_rdata = id_ok ? core_rdata[req_id[IDX_W-1:0]] : '0;

    // response state: next state from the incoming request
    always_comb begin
        if (!req_valid)  state_nx = RS_IDLE;
        else if (!id_ok) state_nx = RS_DERR;
        else             state_nx = RS_DATA;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RS_IDLE;
            rdata_q   <= '0;
            ro_wr_err <= 1'b0;
            snd_done  <= 1'b0;
            snd_err   <= 1'b0;
        end else begin
            state     <= state_nx;
            rdata_q   <= (req_valid && !req_write) ? sel_rdata : '0;
            ro_wr_err <= req_valid && req_write && id_ok && kind == K_STATUS;
            snd_done  <= snd_valid;
            snd_err   <= snd_valid && !tgt_ok;
        end
    end

    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state)
            RS_IDLE: ;
            RS_DATA: begin rsp_valid = 1'b1; rsp_rdata = rdata_q; end
            RS_DERR: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
            default: ;
        endcase
    end
endmodule

// File: rtl/ipi_bank_chk.sv
module ipi_bank_chk #(
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 16,
    parameter int ID_W      = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [ID_W-1:0]      req_id,
    input logic                 rsp_valid,
    input logic                 rsp_err,
    input logic [31:0]          rsp_rdata,
    input logic                 ro_wr_err,
    input logic                 snd_valid,
    input logic [31:0]          snd_cmd,
    input logic                 snd_err,
    input logic [NUM_CORES-1:0] irq
);
    logic id_ok;
    assign id_ok = req_id < ID_W'(NUM_CORES);

    a_r12_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r12_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r2_bad_id_error: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !id_ok) |=> (rsp_err && rsp_rdata == 32'd0));
    a_r3_setclr_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && id_ok && (req_addr[7:2] == 6'd2 || req_addr[7:2] == 6'd3))
        |=> (rsp_rdata == 32'd0 && !rsp_err));
    a_r6_enable_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && id_ok && req_addr[7:2] == 6'd1 && !snd_valid)
        |=> $stable(irq));
    a_r7_status_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && id_ok && req_addr[7:2] == 6'd0) |=> ro_wr_err);
    a_r10_bad_target: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_valid && snd_cmd[25:16] >= 10'(NUM_CORES) && !req_valid)
        |=> (snd_err && $stable(irq)));
    a_r4_rise_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~$past(irq) & irq)) |->
        $past(snd_valid || (req_valid && req_write && req_addr[7:2] == 6'd2)));
    a_r5_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(irq) & ~irq)) |->
        $past(req_valid && req_write && req_addr[7:2] == 6'd3));
endmodule

bind ipi_bank ipi_bank_chk #(
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W),
    .ID_W      (ID_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_id    (req_id),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .ro_wr_err (ro_wr_err),
    .snd_valid (snd_valid),
    .snd_cmd   (snd_cmd),
    .snd_err   (snd_err),
    .irq       (irq)
);

// File: tb/tb_ipi_bank.sv
`timescale 1ns/1ps
module tb_ipi_bank;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [9:0]  req_id = '0;
    logic        rsp_valid, rsp_err, ro_wr_err, snd_done, snd_err;
    logic [31:0] rsp_rdata;
    logic        snd_valid = 1'b0;
    logic [31:0] snd_cmd = '0;
    logic [N-1:0] irq;

    int checks = 0, fails = 0;

    logic [31:0] m_st [N];
    logic [31:0] m_en [N];
    logic [31:0] m_mb [N][8];
    logic [N-1:0] m_irq;

    logic [31:0] q_data[$];
    logic        q_err[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    ipi_bank #(.NUM_CORES(N), .ADDR_W(16), .ID_W(10)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_id(req_id),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .ro_wr_err(ro_wr_err),
        .snd_valid(snd_valid), .snd_cmd(snd_cmd),
        .snd_done(snd_done), .snd_err(snd_err), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: pops expected responses as the design produces them
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_data.size() == 0) begin
                check("R12 unexpected response", 32'd1, 32'd0);
            end else begin
                automatic logic [31:0] ed = q_data.pop_front();
                automatic logic        ee = q_err.pop_front();
                automatic string       tg = q_tag.pop_front();
                check({tg, " rdata"}, rsp_rdata, ed);
                check({tg, " err"}, {31'd0, rsp_err}, {31'd0, ee});
            end
        end
    end

    function automatic void m_set(int c, logic [31:0] v);
        m_st[c] = m_st[c] | v;
        if ((m_st[c] & m_en[c]) != 0) m_irq[c] = 1'b1;
    endfunction

    function automatic void m_clr(int c, logic [31:0] v);
        m_st[c] = m_st[c] & ~v;
        if (m_st[c] == 0 && m_en[c] != 0) m_irq[c] = 1'b0;
    endfunction

    // driver: presents one request and pushes its expected response
    task automatic drive(string tag, bit wr, logic [15:0] a, logic [31:0] wd, logic [9:0] id);
        logic [7:0]  off;
        logic [31:0] ed;
        off = a[7:0];
        ed  = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_id = id;
        if (id < N) begin
            if (!wr) begin
                if (off < 8'h04)                        ed = m_st[id];
                else if (off < 8'h08)                   ed = m_en[id];
                else if (off >= 8'h20 && off < 8'h40)   ed = m_mb[id][(off - 8'h20) >> 2];
            end else begin
                if (off >= 8'h04 && off < 8'h08)        m_en[id] = wd;
                else if (off >= 8'h08 && off < 8'h0C)   m_set(int'(id), wd);
                else if (off >= 8'h0C && off < 8'h10)   m_clr(int'(id), wd);
                else if (off >= 8'h20 && off < 8'h40)   m_mb[id][(off - 8'h20) >> 2] = wd;
            end
        end
        q_data.push_back(ed);
        q_err.push_back(id >= N);
        q_tag.push_back(tag);
    endtask

    task automatic settle();
        @(negedge clk);
        req_valid = 1'b0;
        snd_valid = 1'b0;
    endtask

    task automatic op(string tag, bit wr, logic [15:0] a, logic [31:0] wd, logic [9:0] id);
        drive(tag, wr, a, wd, id);
        settle();
    endtask

    task automatic send(string tag, logic [31:0] cmd);
        logic ok;
        @(negedge clk);
        snd_valid = 1'b1; snd_cmd = cmd;
        ok = cmd[25:16] < N;
        if (ok) m_set(int'(cmd[25:16]), 32'd1 << cmd[4:0]);
        settle();
        check({tag, " snd_done"}, {31'd0, snd_done}, 32'd1);
        check({tag, " snd_err"}, {31'd0, snd_err}, {31'd0, !ok});
    endtask

    task automatic chk_irq(string tag);
        check({tag, " irq"}, {28'd0, irq}, {28'd0, m_irq});
    endtask

    task automatic read_all_status(string tag);
        for (int c = 0; c < N; c++) drive(tag, 1'b0, 16'h0000, 32'd0, 10'(c));
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog expired", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < N; c++) begin
            m_st[c] = '0; m_en[c] = '0;
            for (int w = 0; w < 8; w++) m_mb[c][w] = '0;
        end
        m_irq = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq after reset", {28'd0, irq}, 32'd0);
        check("R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
        op("R1 status zero", 1'b0, 16'h0000, 0, 10'd0);
        op("R1 enable zero", 1'b0, 16'h0004, 0, 10'd2);
        op("R1 mailbox zero", 1'b0, 16'h003C, 0, 10'd3);

        // R8: mailbox words, per core, back-to-back (R12)
        for (int w = 0; w < 8; w++) drive("R8 mbox write", 1'b1, 16'(8'h20 + 4*w), 32'hA500_0000 + w, 10'd1);
        drive("R8 mbox write core2", 1'b1, 16'h0034, 32'h1234_5678, 10'd2);
        for (int w = 0; w < 8; w++) drive("R8 mbox read core1", 1'b0, 16'(8'h20 + 4*w), 0, 10'd1);
        drive("R8 mbox read core2", 1'b0, 16'h0034, 0, 10'd2);
        drive("R8 mbox read core0", 1'b0, 16'h0034, 0, 10'd0);
        settle();

        // R11: upper address bits ignored
        op("R11 enable write high addr", 1'b1, 16'hAB04, 32'h0000_00F0, 10'd0);
        op("R11 enable read", 1'b0, 16'h0004, 0, 10'd0);
        op("R11 mbox read high addr", 1'b0, 16'h7F20, 0, 10'd1);

        // R3: set/clear read zero, unmapped offsets
        op("R3 set reads zero", 1'b0, 16'h0008, 0, 10'd0);
        op("R3 clear reads zero", 1'b0, 16'h000C, 0, 10'd0);
        op("R3 unmapped write", 1'b1, 16'h0010, 32'hFFFF_FFFF, 10'd0);
        op("R3 unmapped read", 1'b0, 16'h0010, 0, 10'd0);
        op("R3 unmapped read 0x44", 1'b0, 16'h0044, 0, 10'd0);

        // R4: set ORs, raise on enabled bit
        op("R4 set bit0", 1'b1, 16'h0008, 32'h0000_0001, 10'd0);
        chk_irq("R4 not enabled bit");
        op("R4 set bit4", 1'b1, 16'h0008, 32'h0000_0010, 10'd0);
        chk_irq("R4 enabled bit raises");
        op("R4 status read", 1'b0, 16'h0000, 0, 10'd0);

        // R5: clear; lowers only when empty and enable nonzero
        op("R5 clear bit4", 1'b1, 16'h000C, 32'h0000_0010, 10'd0);
        chk_irq("R5 partial clear keeps irq");
        op("R5 clear bit0", 1'b1, 16'h000C, 32'h0000_0001, 10'd0);
        chk_irq("R5 empty status lowers");
        op("R5 status read", 1'b0, 16'h0000, 0, 10'd0);

        // R6 / R5: asymmetric rule on core1
        op("R6 enable core1", 1'b1, 16'h0004, 32'h0000_00FF, 10'd1);
        op("R4 set core1", 1'b1, 16'h0008, 32'h0000_0002, 10'd1);
        chk_irq("R4 core1 raise");
        op("R6 enable off", 1'b1, 16'h0004, 32'h0000_0000, 10'd1);
        chk_irq("R6 enable off keeps irq");
        op("R5 clear with enable zero", 1'b1, 16'h000C, 32'h0000_0002, 10'd1);
        chk_irq("R5 enable zero keeps irq");
        op("R6 enable on", 1'b1, 16'h0004, 32'h0000_0001, 10'd1);
        chk_irq("R6 enable on keeps irq");
        op("R5 set core1 bit0", 1'b1, 16'h0008, 32'h0000_0001, 10'd1);
        op("R5 clear core1 bit0", 1'b1, 16'h000C, 32'h0000_0001, 10'd1);
        chk_irq("R5 core1 lowered");

        // R7: status is read-only
        drive("R7 status write", 1'b1, 16'h0000, 32'hFFFF_FFFF, 10'd2);
        settle();
        check("R7 ro_wr_err pulse", {31'd0, ro_wr_err}, 32'd1);
        @(negedge clk);
        check("R7 ro_wr_err single cycle", {31'd0, ro_wr_err}, 32'd0);
        op("R7 status unchanged", 1'b0, 16'h0000, 0, 10'd2);

        // R9: send command
        op("R9 enable core3", 1'b1, 16'h0004, 32'h8000_0000, 10'd3);
        send("R9 send core3 vec31", {6'h3F, 10'd3, 11'h7FF, 5'd31});
        chk_irq("R9 send raises");
        send("R9 send core2 vec0", {6'd0, 10'd2, 11'd0, 5'd0});
        chk_irq("R9 no enable no raise");
        send("R9 send core2 vec5 junk", {6'h15, 10'd2, 11'h0F0, 5'd5});
        read_all_status("R9 status after sends");

        // R10: out-of-range send target
        send("R10 send bad target", {6'd0, 10'd4, 11'd0, 5'd3});
        chk_irq("R10 irq unchanged");
        send("R10 send target 1023", {6'd0, 10'd1023, 11'd0, 5'd7});
        read_all_status("R10 status unchanged");

        // R2: out-of-range requester
        op("R2 read bad id", 1'b0, 16'h0000, 0, 10'd4);
        op("R2 write bad id", 1'b1, 16'h0004, 32'hFFFF_FFFF, 10'd1023);
        chk_irq("R2 irq unchanged");
        for (int c = 0; c < N; c++) drive("R2 enable unchanged", 1'b0, 16'h0004, 0, 10'(c));
        settle();

        // R13: clear and send to the same core in one cycle
        op("R13 set core0", 1'b1, 16'h0008, 32'h0000_0003, 10'd0);
        chk_irq("R13 pre irq");
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h000C;
        req_wdata = 32'h0000_0003; req_id = 10'd0;
        snd_valid = 1'b1; snd_cmd = {6'd0, 10'd0, 11'd0, 5'd4};
        m_clr(0, 32'h0000_0003);
        m_set(0, 32'h0000_0010);
        q_data.push_back(32'd0); q_err.push_back(1'b0); q_tag.push_back("R13 combo write");
        settle();
        chk_irq("R13 combo irq");
        op("R13 combo status", 1'b0, 16'h0000, 0, 10'd0);

        repeat (3) @(negedge clk);
        check("R12 all responses seen", q_data.size(), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule